// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a cycle-accurate, synthesizable model of a fully registered synchronous SRAM. Reads and writes travel down one shared two-stage pipeline. A write's data follows its command by the same distance that a read's data does. Because of this, any sequence of reads, writes and deselects can be issued on consecutive clocks, and the data bus carries one transfer per clock with no turnaround gap.

The bidirectional data bus is split into `dIn`, `dOut` and a drive enable `dOe`. Each data word is made of 9-bit byte lanes: 8 data bits and a parity bit. Each lane has its own active-low write select. A load/advance control either starts a new access or steps a 4-beat burst from the last loaded address. The burst order is linear or interleaved. A clock enable stalls the whole block for as many cycles as it is held low.

Top module: `zt_sram`

## Requirements
- R1: While `rstN` is low and on the first edge after it is released, `dOe` is 0 and `dOut` is all zeros.
- R2: A read that is loaded on enabled edge k with chip selected (`ce1N`=0, `ce2`=1, `ce3N`=0) and `weN`=1 is launched at enabled edge k+1. From then until enabled edge k+2, `dOe`=1 and `dOut` holds the word at its address.
- R3: For a write that is loaded on enabled edge k (`weN`=0), `dIn` and `bwN` are sampled at enabled edge k+2. Lane i is bits [9i+8:9i] of the word. Lane i is stored only when `bwN[i]`=0, and the other lanes keep their old contents.
- R4: Reads, writes and deselects can be issued on every consecutive clock in any order, and each one completes with the timing of R2 and R3.
- R5: A load with any chip enable inactive is a deselect. It writes nothing, and in its data cycle `dOe` is 0.
- R6: In the data cycle of a write (between enabled edges k+1 and k+2), `dOe` is 0.
- R7: At an edge where `clkEn`=0, every input is ignored and all state holds. This covers the pipeline, the burst counter, the array, `dOut` and `dOe`.
- R8: `advLoad`=0 loads a new address and command. `advLoad`=1 advances: the access repeats the loaded read/write type, and the chip enables and `weN` are ignored. With `burstMode`=0, beat n of a burst uses low address bits (base+n) mod 4, and the upper address bits stay unchanged.
- R9: With `burstMode`=1, beat n of a burst uses low address bits base XOR n.
- R10: Advances that follow a deselect load stay deselected. They do not drive the bus and do not write.
- R11: A read whose address matches the write that commits at the same edge as its launch returns the new data in the lanes that write enables, and the array data in the other lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset of the control state and output register |
| clkEn | input | 1 | Clock qualifier; 0 stalls the block |
| ce1N | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3N | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable on a load, active low |
| bwN | input | LANES | Byte lane write selects, active low, sampled with write data |
| advLoad | input | 1 | 0 = load new access, 1 = advance burst |
| burstMode | input | 1 | 0 = linear burst order, 1 = interleaved |
| addr | input | ADDR_W | Word address on a load |
| dIn | input | 9*LANES | Write data from the bus |
| dOut | output | 9*LANES | Registered read data |
| dOe | output | 1 | Bus drive enable for dOut |

## Verification
The bench uses the default build: four lanes (36-bit words) and a 6-bit address, which gives a 64-word array. The array is small enough that every location is written before it is read. Random traffic over 64 addresses often places a read directly after a write to the same word, so the forwarding merge of R11 runs with many partial lane masks. Bursts that start at every low-bit offset exercise both orders through their wrap.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

  localparam int LANE_BITS = 9;

  typedef enum logic {
    ORD_LINEAR      = 1'b0,
    ORD_INTERLEAVED = 1'b1
  } burst_order_e;

  // strobes from control to datapath
  typedef struct packed {
    logic step;      // clock qualifier for this edge
    logic rdLoad;    // stage-1 access is a live read
    logic wrCommit;  // stage-2 access is a live write, data on bus now
    logic fwdHit;    // read and committing write share an address
  } zt_strobe_t;

  function automatic logic [1:0] burstLow(input logic [1:0] base,
                                          input logic [1:0] beat,
                                          input burst_order_e ord);
    logic [1:0] r;
    if (ord == ORD_INTERLEAVED) r = base ^ beat;
    else                        r = base + beat;
    return r;
  endfunction

endpackage

// File: rtl/zt_burst_seq.sv
module zt_burst_seq
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              advLoad,
  input  logic              selIn,
  input  logic              writeIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              burstMode,
  output logic              opValid,
  output logic              opWrite,
  output logic [ADDR_W-1:0] opAddr
);

  logic [ADDR_W-1:0] baseQ;
  logic [1:0]        beatQ;
  logic [1:0]        beatNext;
  logic              validQ;
  logic              writeQ;
  burst_order_e      order;

  assign order    = burst_order_e'(burstMode);
  assign beatNext = beatQ + 2'd1;

  always_comb begin
    if (!advLoad) begin
      opValid = selIn;
      opWrite = writeIn;
      opAddr  = addrIn;
    end else begin
      opValid     = validQ;
      opWrite     = writeQ;
      opAddr      = baseQ;
      opAddr[1:0] = burstLow(baseQ[1:0], beatNext, order);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ  <= '0;
      beatQ  <= '0;
      validQ <= 1'b0;
      writeQ <= 1'b0;
    end else if (clkEn) begin
      if (!advLoad) begin
        baseQ  <= addrIn;
        beatQ  <= 2'd0;
        validQ <= selIn;
        writeQ <= writeIn;
      end else begin
        beatQ  <= beatNext;
      end
    end
  end

endmodule

// File: rtl/zt_ctrl.sv
module zt_ctrl
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              weN,
  input  logic              advLoad,
  input  logic              burstMode,
  input  logic [ADDR_W-1:0] addr,
  output zt_strobe_t        stb,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr
);

  logic              chipSel;
  logic              opValid;
  logic              opWrite;
  logic [ADDR_W-1:0] opAddr;

  logic              s1Valid, s1Write;
  logic [ADDR_W-1:0] s1Addr;
  logic              s2Valid, s2Write;
  logic [ADDR_W-1:0] s2Addr;

  assign chipSel = !ce1N && ce2 && !ce3N;

  zt_burst_seq #(.ADDR_W(ADDR_W)) burstSeq (
    .clk      (clk),
    .rstN     (rstN),
    .clkEn    (clkEn),
    .advLoad  (advLoad),
    .selIn    (chipSel),
    .writeIn  (!weN),
    .addrIn   (addr),
    .burstMode(burstMode),
    .opValid  (opValid),
    .opWrite  (opWrite),
    .opAddr   (opAddr)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Write <= 1'b0;
      s1Addr  <= '0;
      s2Valid <= 1'b0;
      s2Write <= 1'b0;
      s2Addr  <= '0;
    end else if (clkEn) begin
      s1Valid <= opValid;
      s1Write <= opWrite;
      s1Addr  <= opAddr;
      s2Valid <= s1Valid;
      s2Write <= s1Write;
      s2Addr  <= s1Addr;
    end
  end

  always_comb begin
    stb.step     = clkEn;
    stb.rdLoad   = s1Valid && !s1Write;
    stb.wrCommit = s2Valid && s2Write;
    stb.fwdHit   = stb.rdLoad && stb.wrCommit && (s1Addr == s2Addr);
  end

  assign rdAddr = s1Addr;
  assign wrAddr = s2Addr;

endmodule

// File: rtl/zt_datapath.sv
module zt_datapath
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  zt_strobe_t                  stb,
  input  logic [ADDR_W-1:0]           rdAddr,
  input  logic [ADDR_W-1:0]           wrAddr,
  input  logic [LANES*LANE_BITS-1:0]  dIn,
  input  logic [LANES-1:0]            bwN,
  output logic [LANES*LANE_BITS-1:0]  dOut,
  output logic                        dOe
);

  localparam int DATA_W = LANES * LANE_BITS;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] laneMask;
  logic [DATA_W-1:0] rdRaw;
  logic [DATA_W-1:0] rdMerged;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign laneMask[l*LANE_BITS +: LANE_BITS] = {LANE_BITS{!bwN[l]}};
    assign rdMerged[l*LANE_BITS +: LANE_BITS] =
      (stb.fwdHit && !bwN[l]) ? dIn[l*LANE_BITS +: LANE_BITS]
                              : rdRaw[l*LANE_BITS +: LANE_BITS];
  end

  assign rdRaw = mem[rdAddr];

  always_ff @(posedge clk) begin
    if (stb.step && stb.wrCommit)
      mem[wrAddr] <= (mem[wrAddr] & ~laneMask) | (dIn & laneMask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dOut <= '0;
      dOe  <= 1'b0;
    end else if (stb.step) begin
      dOe <= stb.rdLoad;
      if (stb.rdLoad) dOut <= rdMerged;
    end
  end

endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        clkEn,
  input  logic                        ce1N,
  input  logic                        ce2,
  input  logic                        ce3N,
  input  logic                        weN,
  input  logic [LANES-1:0]            bwN,
  input  logic                        advLoad,
  input  logic                        burstMode,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [LANES*LANE_BITS-1:0]  dIn,
  output logic [LANES*LANE_BITS-1:0]  dOut,
  output logic                        dOe
);

  zt_strobe_t        stb;
  logic [ADDR_W-1:0] rdAddr;
  logic [ADDR_W-1:0] wrAddr;

  zt_ctrl #(.ADDR_W(ADDR_W)) ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .clkEn    (clkEn),
    .ce1N     (ce1N),
    .ce2      (ce2),
    .ce3N     (ce3N),
    .weN      (weN),
    .advLoad  (advLoad),
    .burstMode(burstMode),
    .addr     (addr),
    .stb      (stb),
    .rdAddr   (rdAddr),
    .wrAddr   (wrAddr)
  );

  zt_datapath #(.ADDR_W(ADDR_W), .LANES(LANES)) datapath (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .rdAddr(rdAddr),
    .wrAddr(wrAddr),
    .dIn   (dIn),
    .bwN   (bwN),
    .dOut  (dOut),
    .dOe   (dOe)
  );

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       clkEn,
  input logic                       advLoad,
  input logic                       ce1N,
  input logic                       ce2,
  input logic                       ce3N,
  input logic                       weN,
  input logic                       dOe,
  input logic [LANES*LANE_BITS-1:0] dOut,
  input zt_strobe_t                 stb
);

  logic selNow;
  assign selNow = !ce1N && ce2 && !ce3N;

  // R1: first edge out of reset sees an idle bus
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !dOe);

  // R2: a selected read load drives the bus after the next enabled edge
  a_r2_read_drives: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && !advLoad && selNow && weN) ##1 clkEn |=> dOe);

  // R5: a deselect load never drives in its data cycle
  a_r5_deselect_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && !advLoad && !selNow) ##1 clkEn |=> !dOe);

  // R6: write load leaves the bus released in its data cycle
  a_r6_write_released: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && !advLoad && selNow && !weN) ##1 clkEn |=> !dOe);

  // R6: while write data is being committed the driver is off
  a_r6_commit_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrCommit |-> !dOe);

  // R7: stalled edge holds the outputs
  a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> ($stable(dOut) && $stable(dOe)));

  // R10: advance after a deselect load stays off the bus
  a_r10_adv_stays_off: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && !advLoad && !selNow) ##1 (clkEn && advLoad) ##1 clkEn |=> !dOe);

endmodule

bind zt_sram zt_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) chk (.*);

// File: tb/zt_sram_test.sv
module zt_sram_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int LANES  = 4;
  localparam int LB     = 9;
  localparam int DATA_W = LANES * LB;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam logic [2:0] SEL = 3'b010; // {ce1N, ce2, ce3N}

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clkEn = 1'b0, ce1N = 1'b1, ce2 = 1'b0, ce3N = 1'b1, weN = 1'b1;
  logic [LANES-1:0] bwN = '1;
  logic advLoad = 1'b0, burstMode = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] dIn = '0;
  logic [DATA_W-1:0] dOut;
  logic dOe;

  int vectors = 0;
  int miscompares = 0;
  string curReq = "R1";
  bit running = 1'b0;
  bit done = 1'b0;

  zt_sram #(.ADDR_W(ADDR_W), .LANES(LANES)) uut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .weN(weN), .bwN(bwN), .advLoad(advLoad), .burstMode(burstMode), .addr(addr),
    .dIn(dIn), .dOut(dOut), .dOe(dOe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model ----------------
  logic [DATA_W-1:0] refMem [DEPTH];
  logic              p1v = 0, p1w = 0, p2v = 0, p2w = 0;
  logic [ADDR_W-1:0] p1a = '0, p2a = '0;
  logic              bV = 0, bW = 0;
  logic [ADDR_W-1:0] bBase = '0;
  logic [1:0]        bCnt = '0;
  logic              expOe = 0;
  logic [DATA_W-1:0] expOut = '0;
  logic [ADDR_W-1:0] mA;
  logic [DATA_W-1:0] mMask, mWord;

  always @(posedge clk) begin
    if (!rstN) begin
      p1v = 0; p2v = 0; p1w = 0; p2w = 0; bV = 0; bW = 0; bCnt = 0;
      expOe = 0; expOut = '0;
    end else if (clkEn) begin
      if (!advLoad) begin
        bV = !ce1N && ce2 && !ce3N; bW = !weN; bBase = addr; bCnt = 0;
      end else begin
        bCnt = bCnt + 2'd1;
      end
      mA = bBase;
      mA[1:0] = burstMode ? (bBase[1:0] ^ bCnt) : (bBase[1:0] + bCnt);
      for (int l = 0; l < LANES; l++) mMask[l*LB +: LB] = bwN[l] ? '0 : '1;
      if (p1v && !p1w) begin
        mWord = refMem[p1a];
        if (p2v && p2w && p2a == p1a) mWord = (mWord & ~mMask) | (dIn & mMask);
        expOut = mWord; expOe = 1;
      end else begin
        expOe = 0;
      end
      if (p2v && p2w) refMem[p2a] = (refMem[p2a] & ~mMask) | (dIn & mMask);
      p2v = p1v; p2w = p1w; p2a = p1a;
      p1v = bV;  p1w = bW;  p1a = mA;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running && rstN) begin
      check(curReq, "dOe", 64'(dOe), 64'(expOe));
      if (expOe) check(curReq, "dOut", 64'(dOut), 64'(expOut));
    end
  end

  // ---------------- stimulus ----------------
  logic [DATA_W-1:0] wd1 = '0, wd2 = '0;
  logic [LANES-1:0]  wb1 = '1, wb2 = '1;

  function automatic logic [DATA_W-1:0] rndData();
    logic [63:0] t;
    t = {$urandom(), $urandom()};
    return t[DATA_W-1:0];
  endfunction

  task automatic drive(input logic en, input logic ld, input logic [2:0] ce,
                       input logic we, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] wd, input logic [LANES-1:0] wb);
    clkEn = en; advLoad = !ld; {ce1N, ce2, ce3N} = ce; weN = we; addr = a;
    if (en) begin
      dIn = wd2; bwN = wb2;
      wd2 = wd1; wb2 = wb1; wd1 = wd; wb1 = wb;
    end else begin
      dIn = rndData(); bwN = '0;   // garbage while stalled
    end
    @(negedge clk);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                    input logic [LANES-1:0] b);
    drive(1, 1, SEL, 0, a, d, b);
  endtask
  task automatic rd(input logic [ADDR_W-1:0] a);
    drive(1, 1, SEL, 1, a, rndData(), '1);
  endtask
  task automatic adv(input logic [DATA_W-1:0] d, input logic [LANES-1:0] b);
    drive(1, 0, 3'($urandom()), 1'($urandom()), ADDR_W'($urandom()), d, b);
  endtask
  task automatic desel(input logic [2:0] ce, input logic we, input logic [ADDR_W-1:0] a);
    drive(1, 1, ce, we, a, rndData(), '0);
  endtask
  task automatic stall();
    drive(0, 1'($urandom()), 3'($urandom()), 1'($urandom()), ADDR_W'($urandom()),
          rndData(), '0);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) desel(3'b110, 1, '0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1: outputs idle during reset
    check("R1", "dOe in reset", 64'(dOe), 64'd0);
    check("R1", "dOut in reset", 64'(dOut), 64'd0);
    rstN = 1'b1;
    running = 1'b1;
    idle(2);
    check("R1", "dOe after release", 64'(dOe), 64'd0);

    // R3 / R4: fill array with back-to-back full-lane writes
    curReq = "R3";
    for (int a = 0; a < DEPTH; a++) wr(ADDR_W'(a), rndData(), '0);
    idle(2);

    // R2: back-to-back reads
    curReq = "R2";
    for (int a = 0; a < DEPTH; a += 3) rd(ADDR_W'(a));
    idle(2);

    // R3: partial lane writes, then read back
    curReq = "R3";
    for (int m = 0; m < 16; m++) wr(ADDR_W'(m), rndData(), LANES'(m));
    for (int m = 0; m < 16; m++) rd(ADDR_W'(m));
    idle(2);

    // R11: write then immediate read of same address, partial lanes
    curReq = "R11";
    for (int i = 0; i < 12; i++) begin
      wr(ADDR_W'(20 + i), rndData(), LANES'(i));
      rd(ADDR_W'(20 + i));
    end
    wr(ADDR_W'(40), rndData(), 4'b0101);
    rd(ADDR_W'(41));
    rd(ADDR_W'(40));
    idle(3);

    // R6 / R4: alternating write/read with no gaps
    curReq = "R6";
    for (int i = 0; i < 40; i++) begin
      if (i % 2 == 0) wr(ADDR_W'($urandom()), rndData(), LANES'($urandom()));
      else            rd(ADDR_W'($urandom()));
    end
    idle(2);

    // R5: every partial chip-enable combination with a write request
    curReq = "R5";
    for (int c = 0; c < 8; c++) begin
      if (3'(c) != SEL) desel(3'(c), 0, ADDR_W'(5));
    end
    for (int c = 0; c < 8; c++) begin
      if (3'(c) != SEL) desel(3'(c), 1, ADDR_W'(5));
    end
    rd(ADDR_W'(5));
    idle(2);

    // R8: linear bursts from each low-bit offset, read and write
    curReq = "R8";
    burstMode = 1'b0;
    for (int b = 0; b < 4; b++) begin
      wr(ADDR_W'(8 + b), rndData(), '0);
      for (int k = 0; k < 3; k++) adv(rndData(), LANES'($urandom()));
      rd(ADDR_W'(8 + b));
      for (int k = 0; k < 3; k++) adv(rndData(), '1);
    end
    idle(2);

    // R9: interleaved bursts from each low-bit offset
    curReq = "R9";
    burstMode = 1'b1;
    for (int b = 0; b < 4; b++) begin
      wr(ADDR_W'(32 + b), rndData(), '0);
      for (int k = 0; k < 3; k++) adv(rndData(), '0);
      rd(ADDR_W'(32 + b));
      for (int k = 0; k < 5; k++) adv(rndData(), '1);
    end
    idle(2);

    // R10: advances after a deselect load stay deselected
    curReq = "R10";
    desel(3'b000, 0, ADDR_W'(44));
    for (int k = 0; k < 4; k++) adv(rndData(), '0);
    rd(ADDR_W'(44)); rd(ADDR_W'(45)); rd(ADDR_W'(46)); rd(ADDR_W'(47));
    idle(2);

    // R7: stalls inside a mixed stream
    curReq = "R7";
    burstMode = 1'b0;
    wr(ADDR_W'(50), rndData(), '0);
    stall(); stall();
    rd(ADDR_W'(50));
    stall();
    wr(ADDR_W'(51), rndData(), 4'b0011);
    stall(); stall(); stall();
    rd(ADDR_W'(51));
    adv(rndData(), '1);
    stall();
    adv(rndData(), '1);
    idle(3);
    rd(ADDR_W'(50)); rd(ADDR_W'(51));
    idle(2);

    // R4: random traffic with stalls, bursts and deselects
    curReq = "R4";
    for (int i = 0; i < 4000; i++) begin
      int r;
      if (i % 97 == 0) burstMode = 1'($urandom());
      r = $urandom_range(0, 15);
      if (r < 2)       stall();
      else if (r < 4)  adv(rndData(), LANES'($urandom()));
      else if (r < 5)  desel(3'($urandom()) | 3'b001, 1'($urandom()), ADDR_W'($urandom()));
      else if (r < 10) wr(ADDR_W'($urandom()), rndData(), LANES'($urandom()));
      else             rd(ADDR_W'($urandom()));
    end
    idle(4);
    running = 1'b0;
    finishRun();
  end

endmodule